// File: doc/BRIEF.md
# Exception Entry Sequencer for an 8-bit CPU Core

This block handles every way into a new program location that does not come from an instruction: non-maskable and maskable hardware interrupts, the software break, a warm reset and a cold power-up. Interrupt requests are single-cycle pulses that are held in a one-entry pending slot. Reset and power-up requests are held in their own flags. When the core signals an instruction boundary, or at once for the two reset kinds, the sequencer takes over a single-port byte memory bus. For interrupts and break it saves the return address and the flag byte on the page-one stack. It then reads a 16-bit little-endian vector and updates the program counter, stack pointer, flag byte and a running cycle count.

The core owns instruction decode and reads the PC, SP and flag outputs. It can rewrite the flag byte through a write port, for example to clear the interrupt mask. A one-cycle `done` strobe marks the cycle in which the new register values appear. A one-cycle `gpr_clear` strobe tells the core to zero its accumulator and index registers after power-up.

Top module: `irq_entry_seq`

## Requirements
- R1: A pulse on `nmi_req` always makes the pending slot hold NMI, replacing a pending IRQ. A pulse on `irq_req` never replaces a pending NMI. When both pulse in the same cycle, NMI is kept.
- R2: A pulse on `irq_req` while flag bit 2 (interrupt disable) is 1 leaves the pending slot unchanged, so no entry follows at the next boundary.
- R3: Interrupt or break entry writes three bytes to addresses 0x01 concatenated with SP, SP-1 and SP-2, taken modulo 256 so the stack wraps within page one. The bytes are PC[15:8], then PC[7:0], then the flag byte.
- R4: After any pushes, the vector is read as a low byte at the vector address and a high byte at the next address. The vector address is 0xFFFA for NMI, 0xFFFE for IRQ and break, and 0xFFFC for reset and power-up.
- R5: When interrupt or break entry completes, PC equals the vector, SP has dropped by 3, flag bit 2 is 1 and `cycle_count` has grown by 7. `done` is high for exactly that one cycle.
- R6: Break writes the flag byte with bit 4 forced to 1 and leaves bit 4 set in the flag register. Hardware interrupt entry writes the flag byte unchanged. A pending interrupt takes the boundary before a break request in the same cycle.
- R7: A pending interrupt is served only in a cycle where `at_boundary` is 1 and the bus is idle. Serving it empties the slot.
- R8: Power-up performs only the two vector reads. It then sets SP to 0xFD, sets the flag byte to 0x34, zeroes `cycle_count` and pulses `gpr_clear` together with `done`.
- R9: Warm reset performs only the two vector reads. It then sets flag bit 2, zeroes `cycle_count` and leaves SP unchanged.
- R10: A held power-up or reset starts on the next idle cycle without waiting for a boundary, ahead of any pending interrupt or break, and it empties the pending slot. Power-up also absorbs a held reset.
- R11: While `mem_ready` is 0 during a bus access, the address, write enable and write data stay unchanged and the sequence does not advance.
- R12: After a synchronous reset (`rst_n` low), PC, SP, flags and `cycle_count` are zero, and the bus, `done` and `gpr_clear` are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| powerup_req | input | 1 | Cold power-up request pulse |
| reset_req | input | 1 | Warm reset request pulse |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| irq_req | input | 1 | Maskable interrupt request pulse |
| brk_req | input | 1 | Software break request, valid with `at_boundary` |
| at_boundary | input | 1 | Core is between instructions |
| stat_we | input | 1 | Core writes the flag byte |
| stat_wdata | input | 8 | Flag byte value written by the core |
| mem_ready | input | 1 | Bus access completes this cycle |
| mem_rdata | input | 8 | Bus read data |
| mem_en | output | 1 | Bus access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer (page-one offset) |
| status | output | 8 | Flag byte |
| cycle_count | output | 32 | Accumulated entry cycles |
| done | output | 1 | One-cycle strobe: entry finished |
| gpr_clear | output | 1 | One-cycle strobe: clear A, X and Y |
| busy | output | 1 | An entry sequence is in progress |

## Verification
Several request patterns each isolate one rule. An IRQ taken straight after reset, with SP at zero, separates correct page-one wrapping from carrying into page two. IRQ and NMI pulses in both orders, and in the same cycle, separate the override rule from a plain last-request-wins slot. Break issued alone and break issued together with a pending IRQ tell the break bit rule apart from the boundary priority. Reset and power-up issued over a pending IRQ, followed by a long stretch without a boundary, show that the slot is emptied and that service waits for a boundary. A random phase with a stalling bus and scattered requests compares every bus field and register against the bench model in every cycle.

// File: rtl/irq_entry_pkg.sv
// Shared types and constants for the exception entry sequencer.
// Assumes an 8-bit data path and a 16-bit byte address space.
package irq_entry_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    localparam int I_BIT = 2;   // interrupt-disable flag position
    localparam int B_BIT = 4;   // break flag position

    localparam logic [ADDR_W-1:0] VEC_NMI   = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RESET = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ   = 16'hFFFE;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_NMI,
        PEND_IRQ
    } pend_e;

    typedef enum logic [2:0] {
        K_NMI,
        K_IRQ,
        K_BRK,
        K_RST,
        K_PWR
    } entry_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI
    } seq_e;

    // Vector address for each entry kind.
    function automatic logic [ADDR_W-1:0] vector_of(entry_e k);
        case (k)
            K_NMI:        return VEC_NMI;
            K_RST, K_PWR: return VEC_RESET;
            default:      return VEC_IRQ;
        endcase
    endfunction

endpackage

// File: rtl/irq_pend_slot.sv
// One-entry pending slot for hardware interrupt requests.
// An NMI request always takes the slot. An IRQ request takes it only
// while the mask is clear and no NMI is waiting. A clear in the same
// cycle as a new request loses to the request.
module irq_pend_slot
    import irq_entry_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  nmi_req,
    input  logic  irq_req,
    input  logic  irq_mask,
    input  logic  clear,
    output pend_e pend
);

    pend_e base;
    pend_e pend_d;

    // Next slot contents: drop the served entry, then merge new requests.
    always_comb begin
        base   = clear ? PEND_NONE : pend;
        pend_d = base;
        if (nmi_req)
            pend_d = PEND_NMI;
        else if (irq_req && !irq_mask && base != PEND_NMI)
            pend_d = PEND_IRQ;
    end

    // Slot register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= PEND_NONE;
        else        pend <= pend_d;
    end

endmodule

// File: rtl/irq_entry_fsm.sv
// Entry sequencer: picks the next entry kind and drives the byte bus
// through the stack pushes and the vector reads.
// Assumes PC and SP do not change while busy (only commit moves them)
// and that a bus access completes in any cycle with mem_ready high.
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              powerup_req,
    input  logic              reset_req,
    input  logic              at_boundary,
    input  logic              brk_req,
    input  pend_e             pend,
    input  logic              mem_ready,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] pc,
    input  logic [BYTE_W-1:0] sp,
    input  logic [BYTE_W-1:0] status,
    output logic              slot_clr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              commit,
    output entry_e            kind,
    output logic [ADDR_W-1:0] vec_pc
);

    localparam logic [BYTE_W-1:0] BRK_MASK = BYTE_W'(1) << B_BIT;

    seq_e              state;
    logic              pwr_pend;
    logic              rst_pend;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] st_snap;
    logic              idle;
    logic              take_pwr;
    logic              take_rst;
    logic              take_int;
    logic              take_brk;
    logic [ADDR_W-1:0] vec;
    logic [BYTE_W-1:0] sp_m1;
    logic [BYTE_W-1:0] sp_m2;

    // Acceptance priority: power-up, reset, pending interrupt, break.
    always_comb begin
        idle     = (state == ST_IDLE);
        take_pwr = idle && pwr_pend;
        take_rst = idle && !pwr_pend && rst_pend;
        take_int = idle && !pwr_pend && !rst_pend && at_boundary && (pend != PEND_NONE);
        take_brk = idle && !pwr_pend && !rst_pend && at_boundary && (pend == PEND_NONE) && brk_req;
        slot_clr = take_pwr || take_rst || take_int;
        commit   = (state == ST_VEC_HI) && mem_ready;
    end

    // Bus drive for the current access.
    always_comb begin
        vec       = vector_of(kind);
        sp_m1     = sp - BYTE_W'(1);
        sp_m2     = sp - BYTE_W'(2);
        mem_en    = !idle;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = pc[ADDR_W-1:BYTE_W];
            end
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp_m1};
                mem_wdata = pc[BYTE_W-1:0];
            end
            ST_PUSH_ST: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp_m2};
                mem_wdata = st_snap;
            end
            ST_VEC_LO: mem_addr = vec;
            ST_VEC_HI: mem_addr = vec + ADDR_W'(1);
            default: ;
        endcase
        vec_pc = {mem_rdata, lo_q};
    end

    // Request flags for the two reset kinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_pend <= 1'b0;
            rst_pend <= 1'b0;
        end else begin
            pwr_pend <= (pwr_pend && !take_pwr) || powerup_req;
            rst_pend <= (rst_pend && !(take_pwr || take_rst)) || reset_req;
        end
    end

    // Sequence state, entry kind, flag snapshot and low vector byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= K_NMI;
            lo_q    <= '0;
            st_snap <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take_pwr) begin
                        kind  <= K_PWR;
                        state <= ST_VEC_LO;
                    end else if (take_rst) begin
                        kind  <= K_RST;
                        state <= ST_VEC_LO;
                    end else if (take_int) begin
                        kind    <= (pend == PEND_NMI) ? K_NMI : K_IRQ;
                        st_snap <= status;
                        state   <= ST_PUSH_HI;
                    end else if (take_brk) begin
                        kind    <= K_BRK;
                        st_snap <= status | BRK_MASK;
                        state   <= ST_PUSH_HI;
                    end
                end
                ST_PUSH_HI: if (mem_ready) state <= ST_PUSH_LO;
                ST_PUSH_LO: if (mem_ready) state <= ST_PUSH_ST;
                ST_PUSH_ST: if (mem_ready) state <= ST_VEC_LO;
                ST_VEC_LO: if (mem_ready) begin
                    lo_q  <= mem_rdata;
                    state <= ST_VEC_HI;
                end
                ST_VEC_HI: if (mem_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_arch_regs.sv
// Architectural PC, SP and flag registers plus the entry cycle counter.
// Applies the end-of-entry update on commit; otherwise lets the core
// overwrite the flag byte. Commit wins over a core write in the same cycle.
module irq_arch_regs
    import irq_entry_pkg::*;
#(
    parameter int                CYC_W        = 32,
    parameter int                ENTRY_CYCLES = 7,
    parameter int                PUSH_BYTES   = 3,
    parameter logic [BYTE_W-1:0] SP_PWR       = 8'hFD,
    parameter logic [BYTE_W-1:0] ST_PWR       = 8'h34
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  entry_e            kind,
    input  logic [ADDR_W-1:0] vec_pc,
    input  logic              stat_we,
    input  logic [BYTE_W-1:0] stat_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [BYTE_W-1:0] sp,
    output logic [BYTE_W-1:0] status,
    output logic [CYC_W-1:0]  cycle_count,
    output logic              done,
    output logic              gpr_clear
);

    localparam logic [BYTE_W-1:0] I_MASK   = BYTE_W'(1) << I_BIT;
    localparam logic [BYTE_W-1:0] B_MASK   = BYTE_W'(1) << B_BIT;
    localparam logic [BYTE_W-1:0] SP_DROP  = BYTE_W'(PUSH_BYTES);
    localparam logic [CYC_W-1:0]  CYC_STEP = CYC_W'(ENTRY_CYCLES);

    // Register update on entry completion or core flag write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc          <= '0;
            sp          <= '0;
            status      <= '0;
            cycle_count <= '0;
            done        <= 1'b0;
            gpr_clear   <= 1'b0;
        end else begin
            done      <= commit;
            gpr_clear <= commit && (kind == K_PWR);
            if (commit) begin
                pc <= vec_pc;
                case (kind)
                    K_PWR: begin
                        sp          <= SP_PWR;
                        status      <= ST_PWR;
                        cycle_count <= '0;
                    end
                    K_RST: begin
                        status      <= status | I_MASK;
                        cycle_count <= '0;
                    end
                    K_BRK: begin
                        sp          <= sp - SP_DROP;
                        status      <= status | I_MASK | B_MASK;
                        cycle_count <= cycle_count + CYC_STEP;
                    end
                    default: begin
                        sp          <= sp - SP_DROP;
                        status      <= status | I_MASK;
                        cycle_count <= cycle_count + CYC_STEP;
                    end
                endcase
            end else if (stat_we) begin
                status <= stat_wdata;
            end
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Top level of the exception entry sequencer: pending slot, bus
// sequencer and architectural registers. Assumes request inputs are
// single-cycle pulses and that the core holds off its own bus use
// while busy is high.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int          CYC_W        = 32,
    parameter int          ENTRY_CYCLES = 7,
    parameter logic [7:0]  STACK_PAGE   = 8'h01,
    parameter logic [7:0]  SP_PWR       = 8'hFD,
    parameter logic [7:0]  ST_PWR       = 8'h34
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             powerup_req,
    input  logic             reset_req,
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic             brk_req,
    input  logic             at_boundary,
    input  logic             stat_we,
    input  logic [7:0]       stat_wdata,
    input  logic             mem_ready,
    input  logic [7:0]       mem_rdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic [15:0]      pc,
    output logic [7:0]       sp,
    output logic [7:0]       status,
    output logic [CYC_W-1:0] cycle_count,
    output logic             done,
    output logic             gpr_clear,
    output logic             busy
);

    pend_e             pend;
    logic              slot_clr;
    logic              commit;
    entry_e            kind;
    logic [ADDR_W-1:0] vec_pc;

    irq_pend_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .irq_req  (irq_req),
        .irq_mask (status[I_BIT]),
        .clear    (slot_clr),
        .pend     (pend)
    );

    irq_entry_fsm #(
        .STACK_PAGE (STACK_PAGE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .powerup_req (powerup_req),
        .reset_req   (reset_req),
        .at_boundary (at_boundary),
        .brk_req     (brk_req),
        .pend        (pend),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .pc          (pc),
        .sp          (sp),
        .status      (status),
        .slot_clr    (slot_clr),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .commit      (commit),
        .kind        (kind),
        .vec_pc      (vec_pc)
    );

    irq_arch_regs #(
        .CYC_W        (CYC_W),
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .PUSH_BYTES   (3),
        .SP_PWR       (SP_PWR),
        .ST_PWR       (ST_PWR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .kind        (kind),
        .vec_pc      (vec_pc),
        .stat_we     (stat_we),
        .stat_wdata  (stat_wdata),
        .pc          (pc),
        .sp          (sp),
        .status      (status),
        .cycle_count (cycle_count),
        .done        (done),
        .gpr_clear   (gpr_clear)
    );

    assign busy = mem_en;

endmodule

// File: rtl/irq_entry_seq_chk.sv
// Property checker for the exception entry sequencer, attached by bind.
// Observes only the top-level ports.
module irq_entry_seq_chk #(
    parameter int         CYC_W      = 32,
    parameter logic [7:0] STACK_PAGE = 8'h01,
    parameter logic [7:0] SP_PWR     = 8'hFD,
    parameter logic [7:0] ST_PWR     = 8'h34
)(
    input logic             clk,
    input logic             rst_n,
    input logic             mem_ready,
    input logic             mem_en,
    input logic             mem_we,
    input logic [15:0]      mem_addr,
    input logic [7:0]       mem_wdata,
    input logic [7:0]       sp,
    input logic [7:0]       status,
    input logic [CYC_W-1:0] cycle_count,
    input logic             done,
    input logic             gpr_clear,
    input logic             busy
);

    // R3: every write lands in the stack page.
    a_r3_push_in_page_one: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr[15:8] == STACK_PAGE));

    // R4: every read targets the vector area at the top of memory.
    a_r4_vec_read_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (mem_addr[15:4] == 12'hFFF));

    // R5: done lasts a single cycle and comes with the bus released.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: every completed entry leaves interrupts disabled.
    a_r5_ibit_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status[2]);

    // R5: SP moves only in the cycle an entry completes.
    a_r5_sp_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(sp));

    // R8: the register-clear strobe comes with the power-up state.
    a_r8_powerup_state: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_clear |-> (done && sp == SP_PWR && status == ST_PWR && cycle_count == '0));

    // R11: a stalled access holds the bus fields.
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ready) |=> (mem_en && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .CYC_W      (CYC_W),
    .STACK_PAGE (STACK_PAGE),
    .SP_PWR     (SP_PWR),
    .ST_PWR     (ST_PWR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_ready   (mem_ready),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .sp          (sp),
    .status      (status),
    .cycle_count (cycle_count),
    .done        (done),
    .gpr_clear   (gpr_clear),
    .busy        (busy)
);

// File: tb/irq_entry_seq_bench.sv
// Bench: behavioural model built on a queue of expected bus accesses,
// compared against every output on every falling clock edge.
module irq_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        powerup_req = 0, reset_req = 0, nmi_req = 0, irq_req = 0;
    logic        brk_req = 0, at_boundary = 0, stat_we = 0;
    logic [7:0]  stat_wdata = 0;
    logic        mem_ready = 1'b1;
    logic [7:0]  mem_rdata;
    logic        mem_en, mem_we, done, gpr_clear, busy;
    logic [15:0] mem_addr, pc;
    logic [7:0]  mem_wdata, sp, status;
    logic [31:0] cycle_count;

    int    n_chk = 0;
    int    n_fail = 0;
    int    n_cyc = 0;
    string tag = "R12";
    bit    rand_ready = 0;

    logic [7:0] vrom [16];

    always #10 clk = ~clk;

    assign mem_rdata = vrom[mem_addr[3:0]];

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .powerup_req(powerup_req), .reset_req(reset_req),
        .nmi_req(nmi_req), .irq_req(irq_req), .brk_req(brk_req), .at_boundary(at_boundary),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pc(pc), .sp(sp), .status(status), .cycle_count(cycle_count),
        .done(done), .gpr_clear(gpr_clear), .busy(busy)
    );

    // ---------------- reference model ----------------
    // Queue entry: bit 24 write, bits 23:16 data, bits 15:0 address.
    int          q[$];
    int          m_pend = 0;          // 0 none, 1 NMI, 2 IRQ
    bit          m_pwr = 0, m_rst = 0;
    int          m_kind = 0;          // 0 NMI 1 IRQ 2 BRK 3 RST 4 PWR
    logic [15:0] m_pc = 0;
    logic [7:0]  m_sp = 0, m_st = 0;
    logic [31:0] m_cyc = 0;
    bit          m_done = 0, m_gclr = 0;

    function automatic logic [15:0] vec_for(int k);
        if (k == 0) return 16'hFFFA;
        if (k >= 3) return 16'hFFFC;
        return 16'hFFFE;
    endfunction

    function automatic int acc(bit we, logic [7:0] d, logic [15:0] a);
        return (int'(we) << 24) | (int'(d) << 16) | int'(a);
    endfunction

    task automatic plan_reads();
        logic [15:0] v = vec_for(m_kind);
        q.push_back(acc(0, 8'h00, v));
        q.push_back(acc(0, 8'h00, v + 16'd1));
    endtask

    task automatic plan_pushes(logic [7:0] flags);
        logic [7:0] s1 = m_sp - 8'd1;
        logic [7:0] s2 = m_sp - 8'd2;
        q.push_back(acc(1, m_pc[15:8], {8'h01, m_sp}));
        q.push_back(acc(1, m_pc[7:0],  {8'h01, s1}));
        q.push_back(acc(1, flags,      {8'h01, s2}));
        plan_reads();
    endtask

    task automatic finish_entry();
        logic [15:0] v = vec_for(m_kind);
        logic [15:0] v1 = v + 16'd1;
        m_pc = {vrom[v1[3:0]], vrom[v[3:0]]};
        case (m_kind)
            4: begin m_sp = 8'hFD; m_st = 8'h34; m_cyc = 0; m_gclr = 1; end
            3: begin m_st = m_st | 8'h04; m_cyc = 0; end
            2: begin m_sp = m_sp - 8'd3; m_st = m_st | 8'h14; m_cyc = m_cyc + 7; end
            default: begin m_sp = m_sp - 8'd3; m_st = m_st | 8'h04; m_cyc = m_cyc + 7; end
        endcase
        m_done = 1;
    endtask

    always @(posedge clk) begin
        logic [7:0] old_st;
        bit clr;
        old_st = m_st;
        clr = 0;
        if (!rst_n) begin
            q.delete();
            m_pend = 0; m_pwr = 0; m_rst = 0; m_kind = 0;
            m_pc = 0; m_sp = 0; m_st = 0; m_cyc = 0; m_done = 0; m_gclr = 0;
        end else begin
            m_done = 0;
            m_gclr = 0;
            if (q.size() != 0) begin
                if (mem_ready) begin
                    void'(q.pop_front());
                    if (q.size() == 0) finish_entry();
                end
            end else if (m_pwr) begin
                m_kind = 4; plan_reads(); clr = 1; m_pwr = 0; m_rst = 0;
            end else if (m_rst) begin
                m_kind = 3; plan_reads(); clr = 1; m_rst = 0;
            end else if (at_boundary && m_pend != 0) begin
                m_kind = (m_pend == 1) ? 0 : 1; plan_pushes(m_st); clr = 1;
            end else if (at_boundary && brk_req) begin
                m_kind = 2; plan_pushes(m_st | 8'h10);
            end
            if (clr) m_pend = 0;
            if (nmi_req) m_pend = 1;
            else if (irq_req && !old_st[2] && m_pend != 1) m_pend = 2;
            if (powerup_req) m_pwr = 1;
            if (reset_req) m_rst = 1;
            if (!m_done && stat_we) m_st = stat_wdata;
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit e_busy;
        e_busy = (q.size() != 0);
        chk("busy", 32'(busy), 32'(e_busy));
        chk("mem_en", 32'(mem_en), 32'(e_busy));
        if (e_busy) begin
            chk("mem_addr", 32'(mem_addr), 32'(q[0] & 32'hFFFF));
            chk("mem_we", 32'(mem_we), 32'((q[0] >> 24) & 1));
            if (((q[0] >> 24) & 1) != 0)
                chk("mem_wdata", 32'(mem_wdata), 32'((q[0] >> 16) & 32'hFF));
        end
        chk("pc", 32'(pc), 32'(m_pc));
        chk("sp", 32'(sp), 32'(m_sp));
        chk("status", 32'(status), 32'(m_st));
        chk("cycle_count", cycle_count, m_cyc);
        chk("done", 32'(done), 32'(m_done));
        chk("gpr_clear", 32'(gpr_clear), 32'(m_gclr));
    end

    // Random bus stalls for the stall phase.
    always @(negedge clk) begin
        if (rand_ready) mem_ready <= ($urandom % 3) != 0;
        else            mem_ready <= 1'b1;
    end

    // Watchdog.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", n_cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit nmi, input bit irq, input bit brk, input bit bnd,
                         input bit pwr, input bit rst);
        nmi_req = nmi; irq_req = irq; brk_req = brk; at_boundary = bnd;
        powerup_req = pwr; reset_req = rst;
        @(negedge clk);
        nmi_req = 0; irq_req = 0; brk_req = 0; at_boundary = 0;
        powerup_req = 0; reset_req = 0;
    endtask

    task automatic write_flags(logic [7:0] v);
        stat_we = 1; stat_wdata = v;
        @(negedge clk);
        stat_we = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) vrom[i] = 8'h00;
        vrom[4'hA] = 8'h12; vrom[4'hB] = 8'h90;   // NMI    -> 9012
        vrom[4'hC] = 8'h34; vrom[4'hD] = 8'h80;   // reset  -> 8034
        vrom[4'hE] = 8'h56; vrom[4'hF] = 8'hA0;   // IRQ/BRK-> A056

        tag = "R12";
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle_cycles(2);

        tag = "R3";   // IRQ from reset state, SP=0 wraps to 0x01FF / 0x01FE
        pulse(0, 1, 0, 0, 0, 0);
        idle_cycles(2);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(8);

        tag = "R8";
        pulse(0, 0, 0, 0, 1, 0);
        idle_cycles(6);

        tag = "R2";   // flags 0x34 mask IRQ
        pulse(0, 1, 0, 0, 0, 0);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(6);

        tag = "R1";   // NMI then IRQ
        write_flags(8'h20);
        pulse(1, 0, 0, 0, 0, 0);
        pulse(0, 1, 0, 0, 0, 0);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(8);
        write_flags(8'h20);   // IRQ then NMI
        pulse(0, 1, 0, 0, 0, 0);
        pulse(1, 0, 0, 0, 0, 0);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(8);
        write_flags(8'h20);   // both in one cycle
        pulse(1, 1, 0, 0, 0, 0);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(8);

        tag = "R6";   // break alone, then break against a pending IRQ
        pulse(0, 0, 1, 1, 0, 0);
        idle_cycles(8);
        write_flags(8'h00);
        pulse(0, 1, 0, 0, 0, 0);
        pulse(0, 0, 1, 1, 0, 0);
        idle_cycles(8);
        pulse(0, 0, 1, 1, 0, 0);
        idle_cycles(8);

        tag = "R7";   // no service without a boundary; slot empty after
        write_flags(8'h00);
        pulse(0, 1, 0, 0, 0, 0);
        idle_cycles(20);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(8);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(4);

        tag = "R10";  // reset over a pending IRQ empties the slot
        write_flags(8'h00);
        pulse(0, 1, 0, 0, 0, 0);
        pulse(0, 0, 0, 0, 0, 1);
        idle_cycles(6);
        write_flags(8'h00);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(4);
        pulse(1, 0, 0, 0, 0, 0);  // power-up and reset over a pending NMI
        pulse(0, 0, 0, 0, 1, 1);
        idle_cycles(6);
        pulse(0, 0, 0, 1, 0, 0);
        idle_cycles(4);

        tag = "R9";
        write_flags(8'h81);
        pulse(0, 0, 0, 0, 0, 1);
        idle_cycles(6);

        tag = "R11";  // stalling bus with scattered requests
        rand_ready = 1;
        for (int i = 0; i < 3000; i++) begin
            nmi_req     = ($urandom % 40) == 0;
            irq_req     = ($urandom % 12) == 0;
            brk_req     = ($urandom % 15) == 0;
            at_boundary = ($urandom % 4) == 0;
            powerup_req = ($urandom % 400) == 0;
            reset_req   = ($urandom % 250) == 0;
            stat_we     = ($urandom % 20) == 0;
            stat_wdata  = 8'($urandom);
            @(negedge clk);
        end
        nmi_req = 0; irq_req = 0; brk_req = 0; at_boundary = 0;
        powerup_req = 0; reset_req = 0; stat_we = 0;
        rand_ready = 0;
        idle_cycles(12);

        tag = "R12";
        rst_n = 0;
        idle_cycles(3);
        rst_n = 1;
        idle_cycles(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule